// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block buffers 9-bit words between two clock domains. The producer side and the consumer side each run on their own free-running clock. The two clocks may be one shared net or may have no relation at all. Each side accepts a transfer only when both of its enable inputs are high, so two independent agents can each gate the traffic. Storage depth is a parameter. It must be a power of two from 64 to 4096.

Four status outputs describe the occupancy. Empty and almost-empty are produced in the read domain. Full and almost-full are produced in the write domain. Each pointer reaches the opposite domain as a gray code through a flop synchronizer, so a flag can report a pending change late but never early. Both threshold offsets start at 7. They are rewritten by raising the load input and presenting values on the write data bus. The first value goes to the almost-empty offset, the second to the almost-full offset, and the sequence then wraps. A drive-enable output stands in for a three-state read bus.

Top module: `dcf_fifo`

## Requirements
- R1: A word is stored on a write-clock edge only when wr_en_a and wr_en_b are both high, load is low and full is low. With either enable low, the write pointer does not move.
- R2: A word is removed on a read-clock edge only when rd_en_a and rd_en_b are both high and empty is low. The removed word appears on rd_data after that edge, and rd_data holds between reads.
- R3: Words leave in the order they were stored and with their values unchanged. This holds when both clocks are running and unrelated, and also when writes and reads overlap.
- R4: Once the flags have settled, empty is high exactly when the occupancy is 0, and full is high exactly when the occupancy equals DEPTH. The write pointer's gray code changes by at most one bit per write-clock edge.
- R5: A write attempted while full and a read attempted while empty are ignored. Neither pointer moves, and rd_data keeps its value.
- R6: Once settled, almost_empty is high exactly when the occupancy is less than or equal to the almost-empty offset.
- R7: Once settled, almost_full is high exactly when the occupancy is greater than or equal to DEPTH minus the almost-full offset.
- R8: While load is high, each write-clock edge with both write enables high stores wr_data into the next offset. The order is almost-empty offset, then almost-full offset, then almost-empty again. Values above DEPTH-1 saturate to DEPTH-1. A cycle with load low sends the sequencer back to the almost-empty offset.
- R9: Edges on which load is high never store a word into the FIFO.
- R10: Reset (wr_rst and rd_rst together, synchronous, active high) empties the FIFO and returns both offsets to 7. After reset, empty and almost_empty are high and full and almost_full are low.
- R11: rd_oe follows out_en and marks whether the read data bus is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Synchronous reset, write domain, active high |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| load | input | 1 | Redirects enabled writes into the offset sequencer |
| wr_data | input | 9 | Word to store, or offset value while load is high |
| full | output | 1 | No free location (write domain) |
| almost_full | output | 1 | Occupancy within the almost-full offset of DEPTH |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Synchronous reset, read domain, active high |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| out_en | input | 1 | Read bus drive request |
| rd_data | output | 9 | Most recently removed word |
| rd_oe | output | 1 | Drive enable for rd_data |
| empty | output | 1 | No stored word (read domain) |
| almost_empty | output | 1 | Occupancy at or below the almost-empty offset |

## Verification
The hardest states to reach from the ports are the one-word boundaries of the threshold flags after the offsets have been reloaded. A further hard case is proving that the sequencer restarts at the almost-empty offset between load bursts. The bench loads offset pairs and also loads a three-value wrapping burst. It then fills the FIFO to one word below each threshold and exactly onto it. The restart case uses two single-value bursts, then fills to an occupancy where a misdirected value would visibly change almost_full. Pointer wraparound and cross-domain ordering are covered by filling to full after an earlier partial drain, and by a long stretch of overlapping writes and reads on clocks of 5 ns and 7 ns.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  localparam int WORD_W      = 9;
  localparam int OFS_DEFAULT = 7;

  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } ofs_sel_e;
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int           W       = 8,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 2 ** AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_ofs_seq.sv
`timescale 1ns/1ps
module dcf_ofs_seq
  import dcf_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          go,
  input  logic [DW-1:0] data,
  output logic [AW-1:0] ae_ofs,
  output logic [AW-1:0] af_ofs
);
  localparam int MAXV = (2 ** AW) - 1;

  ofs_sel_e      sel_q;
  logic [AW-1:0] val;

  if (AW >= DW) begin : g_wide
    assign val = AW'(data);
  end else begin : g_narrow
    assign val = (data > DW'(MAXV)) ? AW'(MAXV) : data[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= SEL_AE;
      ae_ofs <= AW'(OFS_DEFAULT);
      af_ofs <= AW'(OFS_DEFAULT);
    end else if (!load) begin
      sel_q <= SEL_AE;
    end else if (go) begin
      if (sel_q == SEL_AE) begin
        ae_ofs <= val;
        sel_q  <= SEL_AF;
      end else begin
        af_ofs <= val;
        sel_q  <= SEL_AE;
      end
    end
  end

  // R8: each burst begins at the almost-empty offset
  p_seq_restart_r8: assert property (@(posedge clk) disable iff (rst)
    !load |=> (sel_q == SEL_AE));

  // R8: offsets change only through an enabled load edge
  p_ofs_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(load && go) |=> ($stable(ae_ofs) && $stable(af_ofs)));
endmodule

// File: rtl/dcf_fifo.sv
`timescale 1ns/1ps
module dcf_fifo
  import dcf_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en_a,
  input  logic              wr_en_b,
  input  logic              load,
  input  logic [WORD_W-1:0] wr_data,
  output logic              full,
  output logic              almost_full,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en_a,
  input  logic              rd_en_b,
  input  logic              out_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_oe,
  output logic              empty,
  output logic              almost_empty
);
  localparam int              AW      = $clog2(DEPTH);
  localparam int              PW      = AW + 1;
  localparam logic [PW-1:0]   DEPTH_P = PW'(DEPTH);

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic          wr_both, wr_do;
  logic [PW-1:0] wbin, wgray, wbin_n, wcnt_n, rgray_w;
  logic [AW-1:0] ae_ofs_w, af_ofs_w;

  assign wr_both = wr_en_a & wr_en_b;
  assign wr_do   = wr_both & ~load & ~full;

  always_comb begin
    wbin_n = wbin + PW'(wr_do);
    wcnt_n = wbin_n - gray2bin(rgray_w);
  end

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      wbin        <= '0;
      wgray       <= '0;
      full        <= 1'b0;
      almost_full <= 1'b0;
    end else begin
      wbin        <= wbin_n;
      wgray       <= bin2gray(wbin_n);
      full        <= (wcnt_n == DEPTH_P);
      almost_full <= (wcnt_n >= (DEPTH_P - {1'b0, af_ofs_w}));
    end
  end

  dcf_ofs_seq #(.AW(AW), .DW(WORD_W)) u_ofs (
    .clk    (wr_clk),
    .rst    (wr_rst),
    .load   (load),
    .go     (wr_both),
    .data   (wr_data),
    .ae_ofs (ae_ofs_w),
    .af_ofs (af_ofs_w)
  );

  // ---------------- crossings ----------------
  logic [PW-1:0] rbin, rgray, wgray_r;
  logic [AW-1:0] ae_ofs_r;

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_rptr_sync (
    .clk (wr_clk), .rst (wr_rst), .d (rgray), .q (rgray_w)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_wptr_sync (
    .clk (rd_clk), .rst (rd_rst), .d (wgray), .q (wgray_r)
  );

  dcf_sync #(.W(AW), .STAGES(SYNC_STAGES), .RST_VAL(AW'(OFS_DEFAULT))) u_ae_sync (
    .clk (rd_clk), .rst (rd_rst), .d (ae_ofs_w), .q (ae_ofs_r)
  );

  // ---------------- read domain ----------------
  logic          rd_do;
  logic [PW-1:0] rbin_n, rcnt_n;

  assign rd_do = rd_en_a & rd_en_b & ~empty;

  always_comb begin
    rbin_n = rbin + PW'(rd_do);
    rcnt_n = gray2bin(wgray_r) - rbin_n;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rbin         <= '0;
      rgray        <= '0;
      empty        <= 1'b1;
      almost_empty <= 1'b1;
    end else begin
      rbin         <= rbin_n;
      rgray        <= bin2gray(rbin_n);
      empty        <= (rcnt_n == '0);
      almost_empty <= (rcnt_n <= {1'b0, ae_ofs_r});
    end
  end

  dcf_ram #(.AW(AW), .DW(WORD_W)) u_ram (
    .wr_clk (wr_clk),
    .we     (wr_do),
    .waddr  (wbin[AW-1:0]),
    .wdata  (wr_data),
    .rd_clk (rd_clk),
    .rd_rst (rd_rst),
    .re     (rd_do),
    .raddr  (rbin[AW-1:0]),
    .rdata  (rd_data)
  );

  assign rd_oe = out_en;

  // ---------------- assertions ----------------
  p_wr_pair_r1: assert property (@(posedge wr_clk) disable iff (wr_rst)
    !(wr_en_a && wr_en_b) |=> $stable(wbin));

  p_rd_pair_r2: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !(rd_en_a && rd_en_b) |=> ($stable(rbin) && $stable(rd_data)));

  p_gray_step_r4: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $countones(wgray ^ $past(wgray)) <= 1);

  p_full_hold_r5: assert property (@(posedge wr_clk) disable iff (wr_rst)
    full |=> $stable(wbin));

  p_empty_hold_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
    empty |=> ($stable(rbin) && $stable(rd_data)));

  p_empty_ae_r6: assert property (@(posedge rd_clk) disable iff (rd_rst)
    empty |-> almost_empty);

  p_full_af_r7: assert property (@(posedge wr_clk) disable iff (wr_rst)
    full |-> almost_full);

  p_load_nowrite_r9: assert property (@(posedge wr_clk) disable iff (wr_rst)
    load |=> $stable(wbin));
endmodule

// File: tb/dcf_fifo_tb.sv
`timescale 1ns/1ps
module dcf_fifo_tb;
  localparam int DEPTH = 64;

  logic       wr_clk = 1'b0, rd_clk = 1'b0;
  logic       wr_rst = 1'b1, rd_rst = 1'b1;
  logic       wr_en_a = 1'b0, wr_en_b = 1'b0, load = 1'b0;
  logic [8:0] wr_data = '0;
  logic       rd_en_a = 1'b0, rd_en_b = 1'b0, out_en = 1'b0;
  logic       full, almost_full, empty, almost_empty, rd_oe;
  logic [8:0] rd_data;

  always #2.5 wr_clk = ~wr_clk;   // 200 MHz write clock
  always #3.5 rd_clk = ~rd_clk;   // unrelated read clock

  dcf_fifo #(.DEPTH(DEPTH)) u_dut (
    .wr_clk, .wr_rst, .wr_en_a, .wr_en_b, .load, .wr_data, .full, .almost_full,
    .rd_clk, .rd_rst, .rd_en_a, .rd_en_b, .out_en, .rd_data, .rd_oe, .empty,
    .almost_empty
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [8:0] exp_q[$];
  logic rd_fire = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver side of the scoreboard: record every accepted write
  always @(posedge wr_clk)
    if (!wr_rst && wr_en_a && wr_en_b && !load && !full) exp_q.push_back(wr_data);

  always @(posedge rd_clk) rd_fire <= !rd_rst && rd_en_a && rd_en_b && !empty;

  // monitor: compare every read against the oldest expected word (R2, R3)
  always @(negedge rd_clk)
    if (rd_fire) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 read with nothing expected", int'(rd_data), -1);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R3 data order", int'(rd_data), int'(e));
      end
    end

  task automatic settle();
    repeat (12) @(negedge rd_clk);
  endtask

  task automatic flags(input int occ, input int aeo, input int afo, input string req);
    chk(empty == (occ == 0), {req, " empty"}, int'(empty), int'(occ == 0));
    chk(full == (occ == DEPTH), {req, " full"}, int'(full), int'(occ == DEPTH));
    chk(almost_empty == (occ <= aeo), {req, " almost_empty"}, int'(almost_empty), int'(occ <= aeo));
    chk(almost_full == (occ >= DEPTH - afo), {req, " almost_full"}, int'(almost_full),
        int'(occ >= DEPTH - afo));
  endtask

  task automatic wr_words(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_en_a = 1'b1; wr_en_b = 1'b1; wr_data = 9'(base + i);
    end
    @(negedge wr_clk);
    wr_en_a = 1'b0; wr_en_b = 1'b0;
  endtask

  task automatic rd_words(input int n);
    int got = 0;
    while (got < n) begin
      @(negedge rd_clk);
      if (!empty) begin rd_en_a = 1'b1; rd_en_b = 1'b1; got++; end
      else begin rd_en_a = 1'b0; rd_en_b = 1'b0; end
    end
    @(negedge rd_clk);
    rd_en_a = 1'b0; rd_en_b = 1'b0;
  endtask

  task automatic drain();
    int idle = 0;
    rd_en_a = 1'b1; rd_en_b = 1'b1;
    while (idle < 12) begin
      @(negedge rd_clk);
      if (empty) idle++; else idle = 0;
    end
    rd_en_a = 1'b0; rd_en_b = 1'b0;
    @(negedge rd_clk);
    chk(exp_q.size() == 0, "R3 all words delivered", exp_q.size(), 0);
  endtask

  task automatic load_burst(input int n, input int a, input int b, input int c);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      load = 1'b1; wr_en_a = 1'b1; wr_en_b = 1'b1;
      wr_data = 9'((i == 0) ? a : (i == 1) ? b : c);
    end
    @(negedge wr_clk);
    load = 1'b0; wr_en_a = 1'b0; wr_en_b = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge wr_clk);
    wr_rst = 1'b1; rd_rst = 1'b1;
    repeat (4) @(negedge rd_clk);
    exp_q.delete();
    @(negedge wr_clk); wr_rst = 1'b0;
    @(negedge rd_clk); rd_rst = 1'b0;
    settle();
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [8:0] held;
    do_reset();
    flags(0, 7, 7, "R10 reset");

    // R11: drive enable tracks out_en
    #1 chk(rd_oe == 1'b0, "R11 oe low", int'(rd_oe), 0);
    out_en = 1'b1;
    #1 chk(rd_oe == 1'b1, "R11 oe high", int'(rd_oe), 1);

    // R6 default threshold around 7
    wr_words(5, 10);  settle(); flags(5, 7, 7, "R6 occ5");
    wr_words(3, 15);  settle(); flags(8, 7, 7, "R6 occ8");

    // R1: single write enables do nothing
    @(negedge wr_clk); wr_en_a = 1'b1; wr_data = 9'h1F0;
    repeat (3) @(negedge wr_clk); wr_en_a = 1'b0; wr_en_b = 1'b1;
    repeat (3) @(negedge wr_clk); wr_en_b = 1'b0;
    settle(); flags(8, 7, 7, "R1 single enable write");

    // R2: single read enables do nothing
    @(negedge rd_clk); rd_en_a = 1'b1;
    repeat (3) @(negedge rd_clk); rd_en_a = 1'b0; rd_en_b = 1'b1;
    repeat (3) @(negedge rd_clk); rd_en_b = 1'b0;
    settle(); flags(8, 7, 7, "R2 single enable read");

    rd_words(8); settle(); flags(0, 7, 7, "R4 drained");

    // R5: reads while empty leave pointer and data alone
    held = rd_data;
    @(negedge rd_clk); rd_en_a = 1'b1; rd_en_b = 1'b1;
    repeat (6) @(negedge rd_clk); rd_en_a = 1'b0; rd_en_b = 1'b0;
    chk(rd_data == held, "R5 rd_data held while empty", int'(rd_data), int'(held));
    wr_words(1, 9'h0A5); settle(); rd_words(1); settle();
    flags(0, 7, 7, "R5 after empty reads");

    // R7 / R4 / R5: fill through the almost-full boundary to full
    wr_words(56, 100); settle(); flags(56, 7, 7, "R7 occ56");
    wr_words(1, 156);  settle(); flags(57, 7, 7, "R7 occ57");
    wr_words(7, 157);  settle(); flags(64, 7, 7, "R4 full");
    wr_words(4, 9'h1EE); settle(); flags(64, 7, 7, "R5 writes while full");
    drain(); settle(); flags(0, 7, 7, "R4 empty after drain");

    // R3: overlapping traffic across unrelated clocks
    fork
      wr_words(150, 300);
      rd_words(150);
    join
    settle(); flags(0, 7, 7, "R3 overlap");
    chk(exp_q.size() == 0, "R3 overlap count", exp_q.size(), 0);

    // R8 / R9: load AE=3, AF=10; load edges store nothing
    load_burst(2, 3, 10, 0); settle();
    flags(0, 3, 10, "R9 load no store");
    wr_words(3, 20);  settle(); flags(3, 3, 10, "R6 occ3");
    wr_words(1, 23);  settle(); flags(4, 3, 10, "R6 occ4");
    wr_words(49, 24); settle(); flags(53, 3, 10, "R7 occ53");
    wr_words(1, 73);  settle(); flags(54, 3, 10, "R7 occ54");
    drain(); settle();

    // R8: third value wraps to the almost-empty offset (AE=4, AF=20)
    load_burst(3, 2, 20, 4); settle();
    wr_words(4, 40);  settle(); flags(4, 4, 20, "R8 wrap occ4");
    wr_words(1, 44);  settle(); flags(5, 4, 20, "R8 wrap occ5");
    wr_words(38, 45); settle(); flags(43, 4, 20, "R8 af occ43");
    wr_words(1, 83);  settle(); flags(44, 4, 20, "R8 af occ44");
    drain(); settle();

    // R8: each burst restarts at the almost-empty offset (AE=1, AF stays 20)
    load_burst(1, 6, 0, 0);
    load_burst(1, 1, 0, 0); settle();
    wr_words(1, 90);  settle(); flags(1, 1, 20, "R8 restart occ1");
    wr_words(43, 91); settle(); flags(44, 1, 20, "R8 restart occ44");
    drain(); settle();

    // R10: reset mid-stream restores defaults
    wr_words(10, 200);
    do_reset();
    flags(0, 7, 7, "R10 mid reset");
    wr_words(7, 210); settle(); flags(7, 7, 7, "R10 default ae occ7");
    wr_words(1, 217); settle(); flags(8, 7, 7, "R10 default ae occ8");
    drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule